// File: doc/BRIEF.md
# Double-Rate Pin Register Cell

This block holds the registers of one bidirectional pin cell that moves two bits per clock period in each direction. On the output side, one register is loaded on the rising edge and drives the pin while the clock is high. A second register is loaded on the falling edge and drives the pin while the clock is low. A clock-phase multiplexer picks between the two. The release control, which puts the pin into high impedance, has an identical register pair and multiplexer of its own. On the input side, the pin value is sampled into one register on each edge of a separate receive clock.

The transmit and receive sides each take their own clock and clock enable. One synchronous clear and one synchronous preset act on every register in the cell. Each register sees them at its own sampling edge, and the clear wins over the preset. If the rising-edge data is tied high and the falling-edge data is tied low, the pin output becomes a copy of the transmit clock that stays aligned with double-rate data on neighbouring pins. `WIDTH` places that many independent lanes side by side. The physical pin is outside the block: it is seen as a driven value, a release flag and a sampled value.

Top module: `ddrio_cell`

## Requirements
- R1: When `rst` is 1 at a register's sampling edge, that register becomes 0. This holds whatever `set` and the clock enable are.
- R2: When `set` is 1 and `rst` is 0 at a sampling edge, the register becomes 1, with the clock enable ignored.
- R3: With `out_ce`=1 and no clear or preset, `pad_out` shows `d_rise` taken at the last rising `out_clk` edge while `out_clk` is 1. While `out_clk` is 0 it shows `d_fall` taken at the last falling edge.
- R4: `pad_release` follows `t_rise`/`t_fall` with the same edge and phase rules as R3. A value of 1 means the pin is high impedance.
- R5: With `in_ce`=1, `in_rise` takes `pad_in` at each rising `in_clk` edge and `in_fall` takes it at each falling edge.
- R6: With `out_ce`=0 and no clear or preset, both transmit pairs hold, so `pad_out` and `pad_release` keep repeating their stored values.
- R7: With `in_ce`=0 and no clear or preset, `in_rise` and `in_fall` hold, independently of `out_ce`.
- R8: With `d_rise` all ones, `d_fall` all zeros and `out_ce`=1, `pad_out` equals `out_clk` in every lane from the second transmit period on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| out_clk | input | 1 | Transmit clock; both edges are used |
| out_ce | input | 1 | Transmit clock enable |
| in_clk | input | 1 | Receive clock; both edges are used |
| in_ce | input | 1 | Receive clock enable |
| rst | input | 1 | Synchronous clear for all registers, highest priority |
| set | input | 1 | Synchronous preset for all registers |
| d_rise | input | WIDTH | Data for the high phase |
| d_fall | input | WIDTH | Data for the low phase |
| t_rise | input | WIDTH | Release request for the high phase |
| t_fall | input | WIDTH | Release request for the low phase |
| pad_out | output | WIDTH | Value driven onto the pin |
| pad_release | output | WIDTH | 1 = pin left in high impedance |
| pad_in | input | WIDTH | Value seen on the pin |
| in_rise | output | WIDTH | Pin value captured on rising `in_clk` |
| in_fall | output | WIDTH | Pin value captured on falling `in_clk` |

## Verification
Clear and preset can arrive in the same cycle, and the clear must win on both edges of both clocks. The bench raises both together while the clock enables are high, then raises preset alone while the enables are low. A second overlap is the receive side sampling a pin that the cell itself drives on one phase and releases on the other. Here the receive clock is offset by an eighth of a period. A reference model resolves the pin net from its own transmit state and the external value, and every captured bit is compared against it on every edge.

// File: rtl/ddrio_pkg.sv
package ddrio_pkg;

    // What a register pair does at its next sampling edge, in priority order.
    typedef enum logic [1:0] {
        ACT_HOLD  = 2'd0,
        ACT_LOAD  = 2'd1,
        ACT_SET   = 2'd2,
        ACT_CLEAR = 2'd3
    } pair_act_e;

    function automatic pair_act_e pick_act(input logic clr, input logic pre, input logic en);
        if (clr)      return ACT_CLEAR;
        else if (pre) return ACT_SET;
        else if (en)  return ACT_LOAD;
        return ACT_HOLD;
    endfunction

endpackage

// File: rtl/ddrio_reg_pair.sv
module ddrio_reg_pair
    import ddrio_pkg::*;
#(
    parameter int WIDTH = 1
) (
    input  logic             clk,
    input  logic             ce,
    input  logic             rst,
    input  logic             set,
    input  logic [WIDTH-1:0] d_rise,
    input  logic [WIDTH-1:0] d_fall,
    output logic [WIDTH-1:0] q_rise,
    output logic [WIDTH-1:0] q_fall
);

    typedef struct packed {
        logic [WIDTH-1:0] rise;
        logic [WIDTH-1:0] fall;
    } pair_t;

    pair_t            pair_d;
    pair_act_e        act;
    logic [WIDTH-1:0] rise_q;
    logic [WIDTH-1:0] fall_q;

    always_comb begin
        act         = pick_act(rst, set, ce);
        pair_d.rise = rise_q;
        pair_d.fall = fall_q;
        case (act)
            ACT_CLEAR: pair_d = '0;
            ACT_SET:   pair_d = '1;
            ACT_LOAD: begin
                pair_d.rise = d_rise;
                pair_d.fall = d_fall;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk) rise_q <= pair_d.rise;
    always_ff @(negedge clk) fall_q <= pair_d.fall;

    assign q_rise = rise_q;
    assign q_fall = fall_q;

    // R2: preset loads ones on each edge
    a_r2_set_rise: assert property (@(posedge clk) disable iff (rst)
        set |=> (q_rise == {WIDTH{1'b1}}));
    a_r2_set_fall: assert property (@(negedge clk) disable iff (rst)
        set |=> (q_fall == {WIDTH{1'b1}}));

    // R3 (also R4, R5 for the other instances): enabled edge captures the data
    a_r3_load_rise: assert property (@(posedge clk) disable iff (rst)
        (ce && !set) |=> (q_rise == $past(d_rise)));
    a_r3_load_fall: assert property (@(negedge clk) disable iff (rst)
        (ce && !set) |=> (q_fall == $past(d_fall)));

    // R6 (R7 for the receive instance): disabled edge keeps the value
    a_r6_hold_rise: assert property (@(posedge clk) disable iff (rst)
        (!ce && !set) |=> $stable(q_rise));
    a_r6_hold_fall: assert property (@(negedge clk) disable iff (rst)
        (!ce && !set) |=> $stable(q_fall));

endmodule

// File: rtl/ddrio_phase_mux.sv
module ddrio_phase_mux #(
    parameter int WIDTH = 1
) (
    input  logic             phase,
    input  logic [WIDTH-1:0] hi_val,
    input  logic [WIDTH-1:0] lo_val,
    output logic [WIDTH-1:0] y
);

    for (genvar i = 0; i < WIDTH; i++) begin : g_lane
        assign y[i] = phase ? hi_val[i] : lo_val[i];
    end

endmodule

// File: rtl/ddrio_cell.sv
module ddrio_cell #(
    parameter int WIDTH = 2
) (
    input  logic             out_clk,
    input  logic             out_ce,
    input  logic             in_clk,
    input  logic             in_ce,
    input  logic             rst,
    input  logic             set,
    input  logic [WIDTH-1:0] d_rise,
    input  logic [WIDTH-1:0] d_fall,
    input  logic [WIDTH-1:0] t_rise,
    input  logic [WIDTH-1:0] t_fall,
    output logic [WIDTH-1:0] pad_out,
    output logic [WIDTH-1:0] pad_release,
    input  logic [WIDTH-1:0] pad_in,
    output logic [WIDTH-1:0] in_rise,
    output logic [WIDTH-1:0] in_fall
);

    logic [WIDTH-1:0] dat_hi_q, dat_lo_q;
    logic [WIDTH-1:0] rel_hi_q, rel_lo_q;

    // Transmit data pair and its phase selector
    ddrio_reg_pair #(.WIDTH(WIDTH)) u_dat_pair (
        .clk(out_clk), .ce(out_ce), .rst(rst), .set(set),
        .d_rise(d_rise), .d_fall(d_fall),
        .q_rise(dat_hi_q), .q_fall(dat_lo_q)
    );

    ddrio_phase_mux #(.WIDTH(WIDTH)) u_dat_mux (
        .phase(out_clk), .hi_val(dat_hi_q), .lo_val(dat_lo_q), .y(pad_out)
    );

    // Release pair and its phase selector
    ddrio_reg_pair #(.WIDTH(WIDTH)) u_rel_pair (
        .clk(out_clk), .ce(out_ce), .rst(rst), .set(set),
        .d_rise(t_rise), .d_fall(t_fall),
        .q_rise(rel_hi_q), .q_fall(rel_lo_q)
    );

    ddrio_phase_mux #(.WIDTH(WIDTH)) u_rel_mux (
        .phase(out_clk), .hi_val(rel_hi_q), .lo_val(rel_lo_q), .y(pad_release)
    );

    // Receive pair: both registers sample the same pin
    ddrio_reg_pair #(.WIDTH(WIDTH)) u_cap_pair (
        .clk(in_clk), .ce(in_ce), .rst(rst), .set(set),
        .d_rise(pad_in), .d_fall(pad_in),
        .q_rise(in_rise), .q_fall(in_fall)
    );

endmodule

// File: tb/ddrio_cell_bench.sv
`timescale 1ns/100ps
module ddrio_cell_bench;

    localparam int W = 2;

    logic         out_clk = 1'b0;
    logic         in_clk  = 1'b0;
    logic         out_ce, in_ce, rst, set;
    logic [W-1:0] d_rise, d_fall, t_rise, t_fall, ext;
    logic [W-1:0] pad_out, pad_release, pad_net, in_rise, in_fall;

    int  n_run  = 0;
    int  n_fail = 0;
    bit  checking = 1'b0;
    bit  done = 1'b0;

    always #2 out_clk = ~out_clk;             // 250 MHz
    initial begin
        #0.5;
        forever #2 in_clk = ~in_clk;          // same rate, offset
    end

    // Single pin net: cell drives unless released, then the outside drives.
    assign pad_net = (pad_release & ext) | (~pad_release & pad_out);

    ddrio_cell #(.WIDTH(W)) u_ddrio_cell (
        .out_clk(out_clk), .out_ce(out_ce), .in_clk(in_clk), .in_ce(in_ce),
        .rst(rst), .set(set), .d_rise(d_rise), .d_fall(d_fall),
        .t_rise(t_rise), .t_fall(t_fall), .pad_out(pad_out),
        .pad_release(pad_release), .pad_in(pad_net),
        .in_rise(in_rise), .in_fall(in_fall)
    );

    // Reference model
    logic [W-1:0] m_dh, m_dl, m_th, m_tl, m_ir, m_if;
    logic [W-1:0] m_pad, m_rel, m_net;

    always @(posedge out_clk) begin
        if (rst)         begin m_dh <= '0; m_th <= '0; end
        else if (set)    begin m_dh <= '1; m_th <= '1; end
        else if (out_ce) begin m_dh <= d_rise; m_th <= t_rise; end
    end
    always @(negedge out_clk) begin
        if (rst)         begin m_dl <= '0; m_tl <= '0; end
        else if (set)    begin m_dl <= '1; m_tl <= '1; end
        else if (out_ce) begin m_dl <= d_fall; m_tl <= t_fall; end
    end
    assign m_pad = out_clk ? m_dh : m_dl;
    assign m_rel = out_clk ? m_th : m_tl;
    assign m_net = (m_rel & ext) | (~m_rel & m_pad);

    always @(posedge in_clk) begin
        if (rst)        m_ir <= '0;
        else if (set)   m_ir <= '1;
        else if (in_ce) m_ir <= m_net;
    end
    always @(negedge in_clk) begin
        if (rst)        m_if <= '0;
        else if (set)   m_if <= '1;
        else if (in_ce) m_if <= m_net;
    end

    task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%b expected=%b at %0t", tag, act, exp, $time);
        end
    endtask

    // Compare against the model on every transmit edge, mid-phase
    initial begin
        forever begin
            @(out_clk);
            #1.5;
            if (checking && !done) begin
                chk("R3 pad_out", pad_out, m_pad);
                chk("R4 pad_release", pad_release, m_rel);
                chk("R5 in_rise", in_rise, m_ir);
                chk("R5 in_fall", in_fall, m_if);
            end
        end
    end

    task automatic tick();
        @(posedge out_clk);
        #1;
    endtask

    task automatic summary();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    endtask

    initial begin
        #200000;
        if (!done) begin
            done = 1'b1;
            n_fail++;
            $display("FAIL watchdog expired");
            summary();
            $finish;
        end
    end

    initial begin
        rst = 1'b1; set = 1'b0; out_ce = 1'b1; in_ce = 1'b1;
        d_rise = '0; d_fall = '0; t_rise = '0; t_fall = '0; ext = '0;
        repeat (3) tick();
        #0.5;
        // R1: reset state, high phase then low phase
        chk("R1 reset pad_out hi", pad_out, '0);
        chk("R1 reset release hi", pad_release, '0);
        #2;
        chk("R1 reset pad_out lo", pad_out, '0);
        chk("R1 reset in_rise", in_rise, '0);
        chk("R1 reset in_fall", in_fall, '0);
        tick();
        rst = 1'b0;
        checking = 1'b1;

        // R3/R4/R5: assorted patterns
        for (int i = 0; i < 40; i++) begin
            d_rise = W'($urandom); d_fall = W'($urandom);
            t_rise = W'($urandom); t_fall = W'($urandom);
            ext    = W'($urandom);
            tick();
        end

        // R3: lanes carry distinct values per phase
        t_rise = '0; t_fall = '0; d_rise = 2'b01; d_fall = 2'b10;
        tick(); tick(); #0.5;
        chk("R3 high phase lanes", pad_out, 2'b01);
        #2;
        chk("R3 low phase lanes", pad_out, 2'b10);
        #1.5;

        // R8: forwarded clock
        d_rise = '1; d_fall = '0;
        tick(); tick(); #0.5;
        chk("R8 forward high", pad_out, {W{out_clk}});
        chk("R8 forward high level", pad_out, '1);
        #2;
        chk("R8 forward low", pad_out, '0);
        #1.5;

        // R6: transmit enable low holds the forwarded pattern
        out_ce = 1'b0; d_rise = 2'b00; d_fall = 2'b11; t_rise = '1; t_fall = '1;
        tick(); tick(); tick(); #0.5;
        chk("R6 hold high", pad_out, '1);
        chk("R6 hold release", pad_release, '0);
        #2;
        chk("R6 hold low", pad_out, '0);
        #1.5;

        // R5/R4: released pin, receive captures the outside value
        out_ce = 1'b1; ext = 2'b10;
        tick(); tick(); #0.5;
        chk("R4 released", pad_release, '1);
        chk("R5 capture rise", in_rise, 2'b10);
        chk("R5 capture fall", in_fall, 2'b10);
        #3.5;

        // R7: receive enable low, pin changes, captures hold
        in_ce = 1'b0; ext = 2'b01;
        tick(); tick(); #0.5;
        chk("R7 hold rise", in_rise, 2'b10);
        chk("R7 hold fall", in_fall, 2'b10);
        #3.5;

        // R2: preset with both enables low
        out_ce = 1'b0; set = 1'b1; t_rise = '0; t_fall = '0;
        tick(); tick(); #0.5;
        chk("R2 set pad_out hi", pad_out, '1);
        chk("R2 set release", pad_release, '1);
        chk("R2 set in_rise", in_rise, '1);
        #2;
        chk("R2 set pad_out lo", pad_out, '1);
        chk("R2 set in_fall", in_fall, '1);
        #1.5;

        // R1: clear and preset together, enables high
        out_ce = 1'b1; in_ce = 1'b1; rst = 1'b1;
        tick(); tick(); #0.5;
        chk("R1 priority pad_out hi", pad_out, '0);
        chk("R1 priority release", pad_release, '0);
        chk("R1 priority in_rise", in_rise, '0);
        #2;
        chk("R1 priority pad_out lo", pad_out, '0);
        chk("R1 priority in_fall", in_fall, '0);
        #1.5;
        rst = 1'b0; set = 1'b0;

        // Mixed enables, occasional preset and clear
        for (int i = 0; i < 80; i++) begin
            d_rise = W'($urandom); d_fall = W'($urandom);
            t_rise = W'($urandom); t_fall = W'($urandom);
            ext    = W'($urandom);
            out_ce = 1'($urandom); in_ce = 1'($urandom);
            set    = (($urandom % 10) == 0);
            rst    = (($urandom % 13) == 0);
            tick();
        end
        rst = 1'b0; set = 1'b0;
        tick(); tick();

        done = 1'b1;
        summary();
        $finish;
    end

endmodule